// File: doc/BRIEF.md
# Floating-Point Rounding and Range Unit

This block finishes a floating-point result that an arithmetic unit has left in unpacked form: a class code, a sign, an unbiased exponent and a normalised fraction that carries extra bits below the last bit the target format can keep. It rounds that fraction to single or double precision under one of five rounding modes, and it takes care of results that leave the normal range. Too large a value saturates or becomes infinity. Too small a value is rounded gradually at a shifted bit position, or it collapses to zero or to the smallest denormal. A signalling NaN is made quiet.

The fraction is 61 bits wide by default, with the implicit one at bit 60, so `in_frac[60]` must be set for every number. Double precision keeps 52 fraction bits and rounds away the 8 bits below them. Single precision keeps 23 bits and rounds away 37. Results come out with six status flags. The datapath is combinational. A parameter places an output register after it, and with that register in place the result follows its input strobe by one clock.

Top module: `fp_round_range`

## Requirements
- R1: In default mode (`in_mode`=0), a zero, number or denorm input leaves unchanged and every status bit is 0, even when guard bits are set or the exponent is out of range.
- R2: In nearest mode (`in_mode`=1) the kept fraction increments only when the top guard bit is 1 and either the lowest kept bit or a lower guard bit is 1, so an exact tie goes to the even neighbour. Status bit 1 (rounded) marks an increment.
- R3: In up mode (`in_mode`=2) a positive value with nonzero guard bits increments. In down mode (`in_mode`=3) a negative value with nonzero guard bits increments. Toward-zero mode (`in_mode`=4) never increments. Any nonzero guard bit sets status bit 0 (inexact), and the guard bits are cleared in the result.
- R4: When an increment carries above the implicit bit, the fraction moves right by one and the exponent rises by one.
- R5: An exponent above the maximum (127 single, 1023 double), before or after rounding, raises status bits 2 (overflow) and 0 (inexact). Class 5 (infinity) results in nearest mode, in up mode when positive and in down mode when negative. Otherwise the value saturates to the maximum exponent with every kept fraction bit set.
- R6: Underflow handling raises status bits 3 (underflow) and 0, and sets the exponent to minimum minus kept-fraction width (-1074 double) with the fraction equal to the implicit one. The class becomes 0 (zero) in nearest and toward-zero modes, in up mode when negative and in down mode when positive. Otherwise the class is unchanged.
- R7: An exponent below the minimum (-126 single, -1022 double) rounds at guard count plus (minimum minus exponent). If that count exceeds the fraction width plus one (61), or `in_flush` is 1, or rounding clears the whole fraction, underflow handling follows.
- R8: A value still below the minimum after denormal rounding gets class 2 (denorm) and status bit 4 (denorm). Underflow is added only when inexact is set.
- R9: When `in_tiny_uf` is 1, a value whose exponent was below the minimum, was rounded up into range, and was inexact also raises underflow. When `in_tiny_uf` is 0 it does not.
- R10: A class 4 (signalling NaN) input becomes class 3 (quiet NaN) with only status bit 5 (invalid) set, in every mode. Zero, quiet NaN and infinity inputs pass unchanged with no status.
- R11: `in_dbl`=1 selects double precision (8 guard bits) and `in_dbl`=0 selects single precision (37 guard bits). Limits and the rounding position follow the selection.
- R12: `out_valid` is 1 in the cycle after a cycle with `in_valid` high and 0 otherwise. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_cls | input | 3 | Class: 0 zero, 1 number, 2 denorm, 3 quiet NaN, 4 signalling NaN, 5 infinity |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 14 | Unbiased exponent, two's complement |
| in_frac | input | 61 | Normalised fraction, implicit one at bit 60 |
| in_dbl | input | 1 | 1 = double, 0 = single precision |
| in_mode | input | 3 | 0 default, 1 nearest, 2 up, 3 down, 4 toward zero |
| in_flush | input | 1 | Send every below-range value straight to underflow handling |
| in_tiny_uf | input | 1 | Flag underflow for tiny values rounded into range when inexact |
| out_valid | output | 1 | Result valid |
| out_cls | output | 3 | Result class |
| out_sign | output | 1 | Result sign |
| out_exp | output | 14 | Result exponent |
| out_frac | output | 61 | Result fraction |
| out_status | output | 6 | Bit 0 inexact, 1 rounded, 2 overflow, 3 underflow, 4 denorm, 5 invalid |

## Verification
The hardest cases to reach are at the far end of the denormal range. There the rounding position is 61, one above the top fraction bit, so the implicit one itself is the top guard bit. A value just above that half rounds up into the smallest denormal, and an exact half clears to nothing and falls into underflow handling. The stimulus picks exponents that put the rounding position at exactly 9, 61 and 86. It also uses all-ones fractions, which force the carry chain to wrap. At exponent 1023 that carry drives the value into overflow, and at exponent -1023 it lifts it back into the normal range, where the tiny-underflow control decides the flag.

// File: rtl/fp_round_pkg.sv
// Package: shared encodings for the rounding and range unit.
// Assumes: class, mode and status encodings are fixed by the block's ports.
package fp_round_pkg;

    // value classes
    localparam logic [2:0] CLS_ZERO = 3'd0;
    localparam logic [2:0] CLS_NUM  = 3'd1;
    localparam logic [2:0] CLS_DEN  = 3'd2;
    localparam logic [2:0] CLS_QNAN = 3'd3;
    localparam logic [2:0] CLS_SNAN = 3'd4;
    localparam logic [2:0] CLS_INF  = 3'd5;

    // rounding modes
    localparam logic [2:0] MD_DEF   = 3'd0;
    localparam logic [2:0] MD_NEAR  = 3'd1;
    localparam logic [2:0] MD_UP    = 3'd2;
    localparam logic [2:0] MD_DOWN  = 3'd3;
    localparam logic [2:0] MD_ZERO  = 3'd4;

    // status bit positions
    localparam int ST_INX = 0;
    localparam int ST_RND = 1;
    localparam int ST_OVF = 2;
    localparam int ST_UNF = 3;
    localparam int ST_DEN = 4;
    localparam int ST_INV = 5;
    localparam int ST_W   = 6;

endpackage

// File: rtl/fp_guard_round.sv
// Module: rounds a fraction at a variable guard position.
// Assumes: guards_i is between 1 and NFG+1; bit NFG+1 of frac_i is zero.
// The result has its guard bits cleared; carry_o marks a renormalising shift.
module fp_guard_round
    import fp_round_pkg::*;
#(
    parameter int NFG = 60,
    parameter int GW  = $clog2(NFG + 2) + 1
) (
    input  logic [NFG+1:0] frac_i,
    input  logic [GW-1:0]  guards_i,
    input  logic           sign_i,
    input  logic [2:0]     mode_i,
    output logic [NFG+1:0] frac_o,
    output logic           carry_o,
    output logic           inexact_o,
    output logic           rounded_o
);
    localparam int W = NFG + 2;

    logic [W-1:0] lsb_bit;
    logic [W-1:0] guard_mask;
    logic [W-1:0] half_bit;
    logic [W-1:0] below_half;
    logic [W-1:0] summed;
    logic         any_guard;
    logic         inc;

    // Build the masks for the selected guard position.
    always_comb begin
        lsb_bit    = W'(1) << guards_i;
        guard_mask = lsb_bit - W'(1);
        half_bit   = lsb_bit >> 1;
        below_half = guard_mask >> 1;
    end

    // Decide on the increment from the mode, the sign and the guard bits.
    always_comb begin
        any_guard = |(frac_i & guard_mask);
        inc       = 1'b0;
        if (any_guard) begin
            case (mode_i)
                MD_NEAR: inc = (|(frac_i & half_bit)) &&
                               ((|(frac_i & lsb_bit)) || (|(frac_i & below_half)));
                MD_UP:   inc = !sign_i;
                MD_DOWN: inc = sign_i;
                default: inc = 1'b0;
            endcase
        end
    end

    // Clear the guards, add the increment and renormalise a carry.
    always_comb begin
        summed    = (frac_i & ~guard_mask) + (inc ? lsb_bit : '0);
        carry_o   = summed[W-1];
        frac_o    = carry_o ? (summed >> 1) : summed;
        inexact_o = any_guard;
        rounded_o = inc;
    end

endmodule

// File: rtl/fp_range_sel.sv
// Module: picks the special value for out-of-range results.
// Assumes: the mode is one of the four rounding modes (not default).
// to_inf_o says overflow yields infinity; to_zero_o says underflow yields zero.
module fp_range_sel
    import fp_round_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       sign_i,
    output logic       to_inf_o,
    output logic       to_zero_o
);
    // Map mode and sign to the overflow and underflow outcomes.
    always_comb begin
        to_inf_o  = 1'b0;
        to_zero_o = 1'b0;
        case (mode_i)
            MD_NEAR: begin to_inf_o = 1'b1;     to_zero_o = 1'b1;    end
            MD_UP:   begin to_inf_o = !sign_i;  to_zero_o = sign_i;  end
            MD_DOWN: begin to_inf_o = sign_i;   to_zero_o = !sign_i; end
            MD_ZERO: begin to_inf_o = 1'b0;     to_zero_o = 1'b1;    end
            default: begin to_inf_o = 1'b0;     to_zero_o = 1'b0;    end
        endcase
    end

endmodule

// File: rtl/fp_round_range.sv
// Module: rounding and range unit top.
// Rounds an unpacked value to single or double precision and applies the
// overflow, underflow and denormal rules. An optional output register stage
// (REG_OUT) gives a one-cycle latency.
// Assumes: numbers arrive normalised with the implicit one at bit NFG.
module fp_round_range
    import fp_round_pkg::*;
#(
    parameter int NFG     = 60,
    parameter int EXP_W   = 14,
    parameter int FB_S    = 23,
    parameter int FB_D    = 52,
    parameter int EMAX_S  = 127,
    parameter int EMAX_D  = 1023,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_cls,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [NFG:0]            in_frac,
    input  logic                    in_dbl,
    input  logic [2:0]              in_mode,
    input  logic                    in_flush,
    input  logic                    in_tiny_uf,
    output logic                    out_valid,
    output logic [2:0]              out_cls,
    output logic                    out_sign,
    output logic signed [EXP_W-1:0] out_exp,
    output logic [NFG:0]            out_frac,
    output logic [ST_W-1:0]         out_status
);
    localparam int GW     = $clog2(NFG + 2) + 1;
    localparam int NG_S   = NFG - FB_S;
    localparam int NG_D   = NFG - FB_D;
    localparam int EMIN_S = 1 - EMAX_S;
    localparam int EMIN_D = 1 - EMAX_D;

    int             e_in;
    int             e_max;
    int             e_min;
    int             n_guard;
    int             fbits;
    int             dn_pos;
    int             e_rnd;
    logic           tiny;
    logic           dn_ok;
    logic [GW-1:0]  guard_sel;
    logic [NFG:0]   ovf_frac;

    logic [NFG+1:0] r_frac;
    logic           r_carry;
    logic           r_inx;
    logic           r_rnd;
    logic           to_inf;
    logic           to_zero;

    logic [2:0]              c_cls;
    logic                    c_sign;
    logic signed [EXP_W-1:0] c_exp;
    logic [NFG:0]            c_frac;
    logic [ST_W-1:0]         c_st;

    // Select the precision limits and the rounding position.
    always_comb begin
        e_in      = int'(in_exp);
        e_max     = in_dbl ? EMAX_D : EMAX_S;
        e_min     = in_dbl ? EMIN_D : EMIN_S;
        n_guard   = in_dbl ? NG_D : NG_S;
        fbits     = in_dbl ? FB_D : FB_S;
        tiny      = e_in < e_min;
        dn_pos    = (e_min - e_in) + n_guard;
        dn_ok     = (dn_pos <= NFG + 1) && !in_flush;
        guard_sel = (tiny && dn_ok) ? GW'(dn_pos) : GW'(n_guard);
        ovf_frac  = {(NFG+1){1'b1}} << n_guard;
    end

    fp_guard_round #(
        .NFG (NFG),
        .GW  (GW)
    ) u_round (
        .frac_i    ({1'b0, in_frac}),
        .guards_i  (guard_sel),
        .sign_i    (in_sign),
        .mode_i    (in_mode),
        .frac_o    (r_frac),
        .carry_o   (r_carry),
        .inexact_o (r_inx),
        .rounded_o (r_rnd)
    );

    fp_range_sel u_range (
        .mode_i    (in_mode),
        .sign_i    (in_sign),
        .to_inf_o  (to_inf),
        .to_zero_o (to_zero)
    );

    // Combine class handling, rounding and range handling into one result.
    always_comb begin
        c_cls  = in_cls;
        c_sign = in_sign;
        c_exp  = in_exp;
        c_frac = in_frac;
        c_st   = '0;
        e_rnd  = e_in + (r_carry ? 1 : 0);
        if (in_cls == CLS_SNAN) begin
            c_cls        = CLS_QNAN;
            c_st[ST_INV] = 1'b1;
        end else if ((in_cls == CLS_NUM || in_cls == CLS_DEN) && in_mode != MD_DEF) begin
            if (e_in > e_max) begin
                c_exp        = EXP_W'(e_max);
                c_frac       = ovf_frac;
                c_cls        = to_inf ? CLS_INF : in_cls;
                c_st[ST_OVF] = 1'b1;
                c_st[ST_INX] = 1'b1;
            end else if (tiny && !dn_ok) begin
                c_exp        = EXP_W'(e_min - fbits);
                c_frac       = {1'b1, {NFG{1'b0}}};
                c_cls        = to_zero ? CLS_ZERO : in_cls;
                c_st[ST_UNF] = 1'b1;
                c_st[ST_INX] = 1'b1;
            end else begin
                c_st[ST_INX] = r_inx;
                c_st[ST_RND] = r_rnd;
                if (r_frac[NFG:0] == '0) begin
                    c_exp        = EXP_W'(e_min - fbits);
                    c_frac       = {1'b1, {NFG{1'b0}}};
                    c_cls        = to_zero ? CLS_ZERO : in_cls;
                    c_st[ST_UNF] = 1'b1;
                    c_st[ST_INX] = 1'b1;
                end else if (e_rnd > e_max) begin
                    c_exp        = EXP_W'(e_max);
                    c_frac       = ovf_frac;
                    c_cls        = to_inf ? CLS_INF : in_cls;
                    c_st[ST_OVF] = 1'b1;
                    c_st[ST_INX] = 1'b1;
                end else begin
                    c_exp  = EXP_W'(e_rnd);
                    c_frac = r_frac[NFG:0];
                    if (e_rnd < e_min) begin
                        c_cls        = CLS_DEN;
                        c_st[ST_DEN] = 1'b1;
                        c_st[ST_UNF] = r_inx;
                    end else if (tiny && in_tiny_uf && r_inx) begin
                        c_st[ST_UNF] = 1'b1;
                    end
                end
            end
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            // Register the result and the strobe for one-cycle latency.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid  <= 1'b0;
                    out_cls    <= CLS_ZERO;
                    out_sign   <= 1'b0;
                    out_exp    <= '0;
                    out_frac   <= '0;
                    out_status <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_cls    <= c_cls;
                        out_sign   <= c_sign;
                        out_exp    <= c_exp;
                        out_frac   <= c_frac;
                        out_status <= c_st;
                    end
                end
            end

            AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R12
            AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid); // R12
            AST_DEFAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_mode == MD_DEF && in_cls != CLS_SNAN) |=> out_status == '0); // R1
            AST_ZERO_NO_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_mode == MD_ZERO) |=> !out_status[ST_RND]); // R3
            AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_status[ST_OVF]) |-> out_status[ST_INX]); // R5
            AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_status[ST_UNF]) |-> out_status[ST_INX]); // R8
            AST_SNAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_cls == CLS_SNAN) |=>
                    (out_cls == CLS_QNAN && out_status == (ST_W'(1) << ST_INV))); // R10
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_cls    = c_cls;
            assign out_sign   = c_sign;
            assign out_exp    = c_exp;
            assign out_frac   = c_frac;
            assign out_status = c_st;
        end
    endgenerate

endmodule

// File: tb/fp_round_range_tb.sv
module fp_round_range_tb;

    localparam logic [60:0] IMP  = 61'h1000000000000000;
    localparam logic [60:0] ONES = 61'h1FFFFFFFFFFFFFFF;
    localparam logic [60:0] DMAX = 61'h1FFFFFFFFFFFFF00;
    localparam logic [60:0] SMAX = 61'h1FFFFFE000000000;
    localparam logic [60:0] CRY  = 61'h1FFFFFFFFFFFFF80;

    typedef struct packed {
        logic [2:0]  cls;
        logic        sgn;
        logic [13:0] ex;
        logic [60:0] fr;
        logic        dbl;
        logic [2:0]  md;
        logic        fl;
        logic        ut;
        logic [2:0]  ecls;
        logic        esgn;
        logic [13:0] eex;
        logic [60:0] efr;
        logic [5:0]  est;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    // class 0 zero 1 num 2 den 3 qnan 4 snan 5 inf; mode 0 def 1 near 2 up 3 down 4 zero
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd1,1'b0, 14'sd5, IMP|61'h080,1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP,        6'b000001,4'd2}, // R2 tie even
        '{3'd1,1'b0, 14'sd5, IMP|61'h180,1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP|61'h200,6'b000011,4'd2}, // R2 tie odd
        '{3'd1,1'b0, 14'sd5, IMP|61'h081,1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP|61'h100,6'b000011,4'd2}, // R2 above half
        '{3'd1,1'b0, 14'sd5, IMP|61'h07F,1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP,        6'b000001,4'd2}, // R2 below half
        '{3'd1,1'b0, 14'sd5, IMP|61'h001,1'b1,3'd2,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP|61'h100,6'b000011,4'd3}, // R3 up pos
        '{3'd1,1'b1, 14'sd5, IMP|61'h001,1'b1,3'd2,1'b0,1'b0, 3'd1,1'b1, 14'sd5, IMP,        6'b000001,4'd3}, // R3 up neg
        '{3'd1,1'b1, 14'sd5, IMP|61'h001,1'b1,3'd3,1'b0,1'b0, 3'd1,1'b1, 14'sd5, IMP|61'h100,6'b000011,4'd3}, // R3 down neg
        '{3'd1,1'b0, 14'sd5, IMP|61'h0FF,1'b1,3'd4,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP,        6'b000001,4'd3}, // R3 zero mode
        '{3'd1,1'b0, 14'sd5, IMP|61'h300,1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP|61'h300,6'b000000,4'd3}, // R3 exact
        '{3'd1,1'b0, 14'sd10,CRY,        1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0, 14'sd11,IMP,        6'b000011,4'd4}, // R4 carry
        '{3'd1,1'b0, 14'sd1023,CRY,      1'b1,3'd1,1'b0,1'b0, 3'd5,1'b0, 14'sd1023,DMAX,     6'b000111,4'd5}, // R5 carry to ovf
        '{3'd1,1'b0, 14'sd1024,IMP,      1'b1,3'd4,1'b0,1'b0, 3'd1,1'b0, 14'sd1023,DMAX,     6'b000101,4'd5}, // R5 zero sat
        '{3'd1,1'b1, 14'sd1024,IMP,      1'b1,3'd2,1'b0,1'b0, 3'd1,1'b1, 14'sd1023,DMAX,     6'b000101,4'd5}, // R5 up neg sat
        '{3'd1,1'b1, 14'sd1024,IMP,      1'b1,3'd3,1'b0,1'b0, 3'd5,1'b1, 14'sd1023,DMAX,     6'b000101,4'd5}, // R5 down neg inf
        '{3'd1,1'b0,-14'sd1100,IMP,      1'b1,3'd1,1'b0,1'b0, 3'd0,1'b0,-14'sd1074,IMP,      6'b001001,4'd6}, // R6 near zero
        '{3'd1,1'b0,-14'sd1100,IMP,      1'b1,3'd2,1'b0,1'b0, 3'd1,1'b0,-14'sd1074,IMP,      6'b001001,4'd6}, // R6 up pos min
        '{3'd1,1'b1,-14'sd1100,IMP,      1'b1,3'd2,1'b0,1'b0, 3'd0,1'b1,-14'sd1074,IMP,      6'b001001,4'd6}, // R6 up neg zero
        '{3'd1,1'b0,-14'sd1023,IMP|61'h200,1'b1,3'd1,1'b0,1'b0,3'd2,1'b0,-14'sd1023,IMP|61'h200,6'b010000,4'd8}, // R8 exact denorm
        '{3'd1,1'b0,-14'sd1023,IMP|61'h001,1'b1,3'd4,1'b0,1'b0,3'd2,1'b0,-14'sd1023,IMP,     6'b011001,4'd8}, // R8 inexact denorm
        '{3'd1,1'b0,-14'sd1023,IMP,      1'b1,3'd1,1'b1,1'b0, 3'd0,1'b0,-14'sd1074,IMP,      6'b001001,4'd7}, // R7 flush
        '{3'd1,1'b0,-14'sd1075,IMP|61'h001,1'b1,3'd1,1'b0,1'b0,3'd2,1'b0,-14'sd1074,IMP,     6'b011011,4'd7}, // R7 edge up
        '{3'd1,1'b0,-14'sd1075,IMP,      1'b1,3'd1,1'b0,1'b0, 3'd0,1'b0,-14'sd1074,IMP,      6'b001001,4'd7}, // R7 edge tie
        '{3'd1,1'b0,-14'sd1023,ONES,     1'b1,3'd1,1'b0,1'b1, 3'd1,1'b0,-14'sd1022,IMP,      6'b001011,4'd9}, // R9 tiny uf on
        '{3'd1,1'b0,-14'sd1023,ONES,     1'b1,3'd1,1'b0,1'b0, 3'd1,1'b0,-14'sd1022,IMP,      6'b000011,4'd9}, // R9 tiny uf off
        '{3'd1,1'b0, 14'sd3, IMP|61'h3000000000,1'b0,3'd1,1'b0,1'b0,3'd1,1'b0,14'sd3,IMP|61'h4000000000,6'b000011,4'd11}, // R11 single
        '{3'd1,1'b0, 14'sd128,IMP,       1'b0,3'd1,1'b0,1'b0, 3'd5,1'b0, 14'sd127,SMAX,      6'b000101,4'd11}, // R11 single ovf
        '{3'd4,1'b1, 14'sd7, IMP|61'h5,  1'b1,3'd1,1'b0,1'b0, 3'd3,1'b1, 14'sd7, IMP|61'h5,  6'b100000,4'd10}, // R10 snan
        '{3'd4,1'b0, 14'sd7, IMP,        1'b1,3'd0,1'b0,1'b0, 3'd3,1'b0, 14'sd7, IMP,        6'b100000,4'd10}, // R10 snan default
        '{3'd5,1'b1, 14'sd2000,IMP|61'h1,1'b1,3'd1,1'b0,1'b0, 3'd5,1'b1, 14'sd2000,IMP|61'h1,6'b000000,4'd10}, // R10 inf pass
        '{3'd1,1'b0, 14'sd5, IMP|61'h081,1'b1,3'd0,1'b0,1'b0, 3'd1,1'b0, 14'sd5, IMP|61'h081,6'b000000,4'd1}, // R1 default guards
        '{3'd1,1'b0, 14'sd2000,IMP,      1'b1,3'd0,1'b0,1'b0, 3'd1,1'b0, 14'sd2000,IMP,      6'b000000,4'd1}  // R1 default range
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [2:0]         in_cls = 3'd0;
    logic               in_sign = 1'b0;
    logic signed [13:0] in_exp = '0;
    logic [60:0]        in_frac = '0;
    logic               in_dbl = 1'b1;
    logic [2:0]         in_mode = 3'd0;
    logic               in_flush = 1'b0;
    logic               in_tiny_uf = 1'b0;
    logic               out_valid;
    logic [2:0]         out_cls;
    logic               out_sign;
    logic signed [13:0] out_exp;
    logic [60:0]        out_frac;
    logic [5:0]         out_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fp_round_range u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_cls     (in_cls),
        .in_sign    (in_sign),
        .in_exp     (in_exp),
        .in_frac    (in_frac),
        .in_dbl     (in_dbl),
        .in_mode    (in_mode),
        .in_flush   (in_flush),
        .in_tiny_uf (in_tiny_uf),
        .out_valid  (out_valid),
        .out_cls    (out_cls),
        .out_sign   (out_sign),
        .out_exp    (out_exp),
        .out_frac   (out_frac),
        .out_status (out_status)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic apply_vec(input vec_t v, input int idx);
        @(negedge clk);
        in_valid   = 1'b1;
        in_cls     = v.cls;
        in_sign    = v.sgn;
        in_exp     = v.ex;
        in_frac    = v.fr;
        in_dbl     = v.dbl;
        in_mode    = v.md;
        in_flush   = v.fl;
        in_tiny_uf = v.ut;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_cls !== v.ecls || out_sign !== v.esgn ||
            out_exp !== v.eex || out_frac !== v.efr || out_status !== v.est) begin
            errors++;
            $display("FAIL R%0d vec %0d actual v%0b c%0d s%0b e%0d f%h st%b expected c%0d s%0b e%0d f%h st%b",
                     v.req, idx, out_valid, out_cls, out_sign, out_exp, out_frac, out_status,
                     v.ecls, v.esgn, $signed(v.eex), v.efr, v.est);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R12 reset valid", out_valid, 1'b0);
        check_bit("R12 reset status", |out_status, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R12 idle valid", out_valid, 1'b0);
        for (int i = 0; i < NV; i++) begin
            apply_vec(VEC[i], i);
        end
        // R12: no strobe, no valid
        @(negedge clk);
        check_bit("R12 drop valid", out_valid, 1'b0);
        // R12: back-to-back strobes keep valid high
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        check_bit("R12 b2b first", out_valid, 1'b1);
        @(negedge clk);
        check_bit("R12 b2b second", out_valid, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R12 b2b end", out_valid, 1'b0);
        // R12: reset in mid run clears valid
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        check_bit("R12 mid reset", out_valid, 1'b0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule